// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Address Filter

This block takes one asynchronous serial line and turns it into data words. A sample tick, supplied from outside at sixteen times the bit rate, drives a bit engine. The engine finds the falling edge of a start bit and confirms it at mid-bit. It then decides each data bit and the stop bit by a majority of three samples taken at the middle of the bit. Frames carry 8 data bits, or 9 when the wide mode is on. Bits arrive least significant first.

Each completed word, with its ninth bit and a framing-error mark, goes into a two-entry FIFO. The head entry appears on the read port, and a pop strobe removes it. A ready flag shows that the FIFO holds data, and an interrupt follows that flag when the interrupt enable is set. A frame that completes while the FIFO is full latches an overrun error. The receiver then stops taking frames until the receive enable is dropped and raised again.

For multidrop buses an address-only mode can be set in 9-bit operation. In that mode, frames whose ninth bit is 0 are thrown away. Once software clears the mode, every frame is stored again.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset `rx_ready`, `irq`, `frame_err` and `overrun_err` are all 0.
- R2: In 8-bit mode a frame is one low start bit, 8 data bits least significant first and one high stop bit. The stored word appears on `rd_data`, with `rd_bit9` = 0.
- R3: With `nine_bit_en` = 1 a ninth data bit follows the eighth. It is reported on `rd_bit9`, apart from the 8-bit `rd_data`.
- R4: The FIFO holds two words in arrival order. `rx_ready` is 1 while it is not empty, and a one-cycle `rd_pop` removes the head. A pop on an empty FIFO has no effect.
- R5: A frame that completes while the FIFO is full is dropped and sets `overrun_err`. While `overrun_err` is 1 no frame is accepted, and the words already stored stay readable.
- R6: A frame whose stop bit is decided as 0 is still stored. `frame_err` is 1 while that word is at the head and 0 for words with a good stop bit.
- R7: `irq` is 1 exactly when `rx_ready` and `irq_en` are both 1.
- R8: Setting `rx_en` to 0 clears `overrun_err`. After `rx_en` returns to 1, frames are accepted again.
- R9: Frames that arrive while `port_en` or `rx_en` is 0 are ignored.
- R10: With `nine_bit_en` = 1 and `addr_only` = 1, a frame whose ninth bit is 0 is discarded without setting any flag or error, and a frame whose ninth bit is 1 is stored. With `addr_only` = 0 all frames are stored.
- R11: Each bit is the majority of the samples at tick positions 7, 8 and 9 of the 16 in that bit, so one wrong sample at position 8 does not change the decoded bit.
- R12: A low level seen on the line that is high again at mid-bit of the supposed start bit returns the receiver to idle and loads nothing. A following frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| port_en | input | 1 | Serial port enable |
| rx_en | input | 1 | Continuous receive enable; 0 clears the overrun error |
| nine_bit_en | input | 1 | 1 selects 9 data bits per frame |
| addr_only | input | 1 | In 9-bit mode, keep only frames whose ninth bit is 1 |
| irq_en | input | 1 | Interrupt enable |
| rd_pop | input | 1 | One-cycle strobe that removes the head word |
| rd_data | output | 8 | Head word, data bits |
| rd_bit9 | output | 1 | Head word, ninth bit |
| rx_ready | output | 1 | FIFO holds at least one word |
| frame_err | output | 1 | Head word had a low stop bit |
| overrun_err | output | 1 | A frame was lost to a full FIFO |
| irq | output | 1 | Ready flag gated by the interrupt enable |

## Verification
Every 8-bit value is sent once and read back. A bit swapped, dropped or shifted in position shows up as a wrong word. Ninth-bit patterns that alternate against the low byte separate the ninth bit from the data bits. Frames with one corrupted mid-bit sample test the vote, and a short low pulse tests start rejection. Bursts of two, three and four frames without reads, a frame with a low stop bit, disabled ports and the address filter turned on and off each probe the storage, the error flags and the admission path on their own.

// File: rtl/uart_rx_pkg.sv
// Shared types for the serial receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package uart_rx_pkg;

    // Frame position of the bit engine.
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    // Two-out-of-three vote over the mid-bit samples.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
// Brings the asynchronous serial line into the clock domain.
// Assumes: STAGES >= 1; the line idles high, so reset fills the chain with ones.
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single register stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= line_in;
            end
        end else begin : g_multi
            // Shift the line through the stages.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], line_in};
            end
        end
    endgenerate

    assign line_out = chain[STAGES-1];
endmodule

// File: rtl/rx_bit_engine.sv
// Oversampling bit engine. It finds a start edge and confirms it at mid-bit,
// then decides each bit by a majority of three mid-bit samples and assembles
// the word LSB first.
// Assumes: tick pulses OSR times per bit; OSR >= 8 and even; the word is
// cleared at every start. 'done' pulses for one cycle after the stop decision.
module rx_bit_engine
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx,
    input  logic              active,
    input  logic              nine_bit,
    output logic              done,
    output logic              stop_ok,
    output logic [DATA_W:0]   word
);
    localparam int CW = $clog2(OSR);
    localparam int IW = $clog2(DATA_W + 1);
    localparam logic [CW-1:0] POS_A   = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] POS_B   = CW'(OSR / 2);
    localparam logic [CW-1:0] POS_C   = CW'(OSR / 2 + 1);
    localparam logic [CW-1:0] POS_END = CW'(OSR - 1);
    localparam logic [IW-1:0] IDX_LO  = IW'(DATA_W - 1);
    localparam logic [IW-1:0] IDX_HI  = IW'(DATA_W);

    rx_state_e     state;
    logic [CW-1:0] cnt;
    logic [IW-1:0] bit_idx;
    logic [1:0]    hist;
    logic          vote;
    logic [IW-1:0] last_idx;

    // Majority of the two stored samples and the current one.
    assign vote     = maj3(hist[0], hist[1], rx);
    // Index of the final data bit for the selected frame length.
    assign last_idx = nine_bit ? IDX_HI : IDX_LO;

    // Frame sequencing, sampling and word assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            hist    <= '0;
            word    <= '0;
            done    <= 1'b0;
            stop_ok <= 1'b0;
        end else if (!active) begin
            state <= RX_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                if (state == RX_IDLE) begin
                    if (!rx) begin
                        state   <= RX_START;
                        cnt     <= CW'(1);
                        word    <= '0;
                        bit_idx <= '0;
                    end
                end else begin
                    cnt <= (cnt == POS_END) ? '0 : cnt + 1'b1;
                    if (cnt == POS_A) hist[0] <= rx;
                    if (cnt == POS_B) hist[1] <= rx;
                    if (cnt == POS_C) begin
                        case (state)
                            RX_START: if (vote) state <= RX_IDLE;
                            RX_DATA:  word[bit_idx] <= vote;
                            RX_STOP: begin
                                done    <= 1'b1;
                                stop_ok <= vote;
                                state   <= RX_IDLE;
                            end
                            default: ;
                        endcase
                    end
                    if (cnt == POS_END) begin
                        case (state)
                            RX_START: begin
                                state   <= RX_DATA;
                                bit_idx <= '0;
                            end
                            RX_DATA: begin
                                if (bit_idx == last_idx) state <= RX_STOP;
                                else                     bit_idx <= bit_idx + 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rx_word_fifo.sv
// Small first-in first-out store for received words.
// Assumes: push is already qualified by the caller; pop on empty is ignored;
// push and pop in the same cycle on a full store is allowed.
module rx_word_fifo #(
    parameter int WIDTH = 10,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0]   PTR_LAST = PW'(DEPTH - 1);
    localparam logic [CNTW-1:0] CNT_FULL = CNTW'(DEPTH);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CNTW-1:0]  count;
    logic             do_pop, do_push;

    // Qualify the strobes against the current occupancy.
    assign do_pop  = pop & ~empty;
    assign do_push = push & (~full | do_pop);
    assign empty   = (count == '0);
    assign full    = (count == CNT_FULL);
    assign rdata   = slots[rd_ptr];

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Storage write; contents are only meaningful while counted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else if (do_push) begin
            slots[wr_ptr] <= wdata;
        end
    end
endmodule

// File: rtl/uart_addr_rx.sv
// Asynchronous serial receiver top. It joins the line synchronizer, the bit
// engine and the word FIFO, and adds the address filter, the overrun latch and
// the interrupt gate.
// Assumes: smp_tick comes from an external rate generator at OSR times the bit
// rate; FIFO entry layout is {frame error, ninth bit, data}.
module uart_addr_rx #(
    parameter int DATA_W      = 8,
    parameter int OSR         = 16,
    parameter int FIFO_DEPTH  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_tick,
    input  logic              rxd,
    input  logic              port_en,
    input  logic              rx_en,
    input  logic              nine_bit_en,
    input  logic              addr_only,
    input  logic              irq_en,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_bit9,
    output logic              rx_ready,
    output logic              frame_err,
    output logic              overrun_err,
    output logic              irq
);
    localparam int ENTRY_W = DATA_W + 2;

    logic               rx_s;
    logic               eng_active;
    logic               frm_done;
    logic               frm_stop_ok;
    logic [DATA_W:0]    frm_word;
    logic               frm_keep;
    logic               push_ok;
    logic               pop_eff;
    logic               fifo_full, fifo_empty;
    logic [ENTRY_W-1:0] head;
    logic               ovr_q;

    rx_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (rxd),
        .line_out (rx_s)
    );

    // The engine runs only while enabled and not stalled by an overrun.
    assign eng_active = port_en & rx_en & ~ovr_q;

    rx_bit_engine #(.DATA_W(DATA_W), .OSR(OSR)) i_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (smp_tick),
        .rx       (rx_s),
        .active   (eng_active),
        .nine_bit (nine_bit_en),
        .done     (frm_done),
        .stop_ok  (frm_stop_ok),
        .word     (frm_word)
    );

    // Address filter: in 9-bit address mode keep only frames marked as address.
    assign frm_keep = ~(nine_bit_en & addr_only & ~frm_word[DATA_W]);
    // A pop frees a slot in the same cycle, so a push may then proceed.
    assign pop_eff  = rd_pop & ~fifo_empty;
    assign push_ok  = frm_done & frm_keep & (~fifo_full | pop_eff);

    rx_word_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_ok),
        .pop   (rd_pop),
        .wdata ({~frm_stop_ok, frm_word}),
        .rdata (head),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    // Overrun latch: set on a kept frame with no room, cleared by rx_en low.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        ovr_q <= 1'b0;
        else if (!rx_en)                                   ovr_q <= 1'b0;
        else if (frm_done & frm_keep & fifo_full & ~pop_eff) ovr_q <= 1'b1;
    end

    assign rd_data     = head[DATA_W-1:0];
    assign rd_bit9     = head[DATA_W];
    assign frame_err   = head[DATA_W+1] & ~fifo_empty;
    assign rx_ready    = ~fifo_empty;
    assign overrun_err = ovr_q;
    assign irq         = rx_ready & irq_en;
endmodule

// File: rtl/uart_rx_checker.sv
// Temporal checks on the receiver top, attached by bind.
// Assumes: connected to the top's ports and its internal frame/push strobes.
module uart_rx_checker (
    input logic clk,
    input logic rst_n,
    input logic rx_en,
    input logic irq,
    input logic irq_en,
    input logic rx_ready,
    input logic overrun_err,
    input logic frm_done,
    input logic push_ok,
    input logic fifo_full
);
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en);                                            // R7
    AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rx_ready);                                          // R7
    AST_READY_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok |=> rx_ready);                                      // R4
    AST_OVERRUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_err && rx_en) |=> overrun_err);                    // R5
    AST_OVERRUN_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_err) |-> $past(fifo_full));                   // R5
    AST_NO_FRAME_IN_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |-> !overrun_err);                                 // R5
    AST_OVERRUN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !overrun_err);                                   // R8
endmodule

bind uart_addr_rx uart_rx_checker i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_en       (rx_en),
    .irq         (irq),
    .irq_en      (irq_en),
    .rx_ready    (rx_ready),
    .overrun_err (overrun_err),
    .frm_done    (frm_done),
    .push_ok     (push_ok),
    .fifo_full   (fifo_full)
);

// File: tb/test_uart_addr_rx.sv
// Self-checking bench: 125 MHz clock, sample tick every second cycle,
// so one serial bit lasts 32 clocks.
module test_uart_addr_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       port_en = 1'b1;
    logic       rx_en = 1'b1;
    logic       nine_bit_en = 1'b0;
    logic       addr_only = 1'b0;
    logic       irq_en = 1'b0;
    logic       rd_pop = 1'b0;
    logic [7:0] rd_data;
    logic       rd_bit9, rx_ready, frame_err, overrun_err, irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit tick_ph = 1'b0;

    uart_addr_rx i_uart_addr_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_tick    (smp_tick),
        .rxd         (rxd),
        .port_en     (port_en),
        .rx_en       (rx_en),
        .nine_bit_en (nine_bit_en),
        .addr_only   (addr_only),
        .irq_en      (irq_en),
        .rd_pop      (rd_pop),
        .rd_data     (rd_data),
        .rd_bit9     (rd_bit9),
        .rx_ready    (rx_ready),
        .frame_err   (frame_err),
        .overrun_err (overrun_err),
        .irq         (irq)
    );

    always #4 clk = ~clk;

    // Tick on every other clock.
    always @(posedge clk) begin
        tick_ph  <= ~tick_ph;
        smp_tick <= tick_ph;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One bit of 32 clocks; optional one-tick inversion at sample position 8.
    task automatic drive_bit(input logic b, input bit glitch);
        rxd = b;
        if (glitch) begin
            wait_clk(16);
            rxd = ~b;
            wait_clk(2);
            rxd = b;
            wait_clk(14);
        end else begin
            wait_clk(32);
        end
    endtask

    // Whole frame plus one idle bit; gl selects the data bit to disturb (-1: none).
    task automatic send_frame(input logic [8:0] w, input bit nine, input logic stop_v, input int gl);
        drive_bit(1'b0, 1'b0);
        for (int i = 0; i < (nine ? 9 : 8); i++) drive_bit(w[i], i == gl);
        drive_bit(stop_v, 1'b0);
        drive_bit(1'b1, 1'b0);
        rxd = 1'b1;
    endtask

    task automatic pop_word();
        rd_pop = 1'b1;
        wait_clk(1);
        rd_pop = 1'b0;
        wait_clk(1);
    endtask

    function automatic logic [31:0] head_of();
        return {22'd0, frame_err, rd_bit9, rd_data};
    endfunction

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);

        // R1: reset state
        check("R1 ready", rx_ready, 0);
        check("R1 irq", irq, 0);
        check("R1 frame_err", frame_err, 0);
        check("R1 overrun", overrun_err, 0);

        // R2: every 8-bit value
        for (int v = 0; v < 256; v++) begin
            send_frame(9'(v), 1'b0, 1'b1, -1);
            check("R2 word", {rx_ready, head_of()}, {1'b1, 22'd0, 2'b00, 8'(v)});
            pop_word();
        end
        check("R2 drained", rx_ready, 0);

        // R11: one wrong sample at position 8 of each data bit
        for (int i = 0; i < 8; i++) begin
            logic [7:0] v;
            v = 8'h5A ^ 8'(i * 29);
            send_frame({1'b0, v}, 1'b0, 1'b1, i);
            check("R11 vote", head_of(), {24'd0, v});
            pop_word();
        end

        // R3: ninth bit patterns
        nine_bit_en = 1'b1;
        for (int i = 0; i < 24; i++) begin
            logic [8:0] w;
            w = 9'((i * 83 + 17) & 9'h1FF);
            w[8] = i[0] ^ w[0];
            send_frame(w, 1'b1, 1'b1, -1);
            check("R3 nine", head_of(), {23'd0, w});
            pop_word();
        end
        nine_bit_en = 1'b0;

        // R4: two-deep ordering and pop on empty
        send_frame(9'h0C3, 1'b0, 1'b1, -1);
        send_frame(9'h03C, 1'b0, 1'b1, -1);
        check("R4 first", head_of(), 32'h0C3);
        pop_word();
        check("R4 second", head_of(), 32'h03C);
        pop_word();
        check("R4 empty", rx_ready, 0);
        pop_word();
        send_frame(9'h0E7, 1'b0, 1'b1, -1);
        check("R4 pop empty ignored", {rx_ready, head_of()}, {1'b1, 32'h0E7});
        pop_word();

        // R5: overrun and stall
        send_frame(9'h011, 1'b0, 1'b1, -1);
        send_frame(9'h022, 1'b0, 1'b1, -1);
        check("R5 no overrun at two", overrun_err, 0);
        send_frame(9'h033, 1'b0, 1'b1, -1);
        check("R5 overrun set", overrun_err, 1);
        send_frame(9'h044, 1'b0, 1'b1, -1);
        check("R5 head kept", head_of(), 32'h011);
        pop_word();
        check("R5 second kept", head_of(), 32'h022);
        pop_word();
        send_frame(9'h055, 1'b0, 1'b1, -1);
        check("R5 stalled", {rx_ready, overrun_err}, 2'b01);

        // R8: clearing rx_en clears overrun and restores reception
        rx_en = 1'b0;
        wait_clk(2);
        check("R8 overrun cleared", overrun_err, 0);
        rx_en = 1'b1;
        wait_clk(2);
        send_frame(9'h066, 1'b0, 1'b1, -1);
        check("R8 resumed", {rx_ready, head_of()}, {1'b1, 32'h066});
        pop_word();

        // R6: framing error follows its word
        send_frame(9'h09D, 1'b0, 1'b0, -1);
        send_frame(9'h0D9, 1'b0, 1'b1, -1);
        check("R6 bad stop", head_of(), 32'h29D);
        pop_word();
        check("R6 good stop", head_of(), 32'h0D9);
        pop_word();

        // R7: interrupt gate
        send_frame(9'h0A1, 1'b0, 1'b1, -1);
        check("R7 masked", irq, 0);
        irq_en = 1'b1;
        wait_clk(1);
        check("R7 raised", irq, 1);
        pop_word();
        check("R7 dropped when empty", irq, 0);
        irq_en = 1'b0;

        // R9: disabled port or receiver
        port_en = 1'b0;
        send_frame(9'h0F0, 1'b0, 1'b1, -1);
        check("R9 port off", rx_ready, 0);
        port_en = 1'b1;
        rx_en = 1'b0;
        send_frame(9'h00F, 1'b0, 1'b1, -1);
        check("R9 rx off", rx_ready, 0);
        rx_en = 1'b1;
        wait_clk(2);

        // R10: address filter
        nine_bit_en = 1'b1;
        addr_only = 1'b1;
        send_frame(9'h0B4, 1'b1, 1'b1, -1);
        check("R10 data dropped", {rx_ready, frame_err, overrun_err}, 3'b000);
        send_frame(9'h1A5, 1'b1, 1'b1, -1);
        check("R10 address kept", head_of(), 32'h1A5);
        pop_word();
        addr_only = 1'b0;
        send_frame(9'h03C, 1'b1, 1'b1, -1);
        check("R10 filter off", head_of(), 32'h03C);
        pop_word();
        nine_bit_en = 1'b0;

        // R12: short low pulse is not a start bit
        rxd = 1'b0;
        wait_clk(4);
        rxd = 1'b1;
        wait_clk(64);
        check("R12 glitch ignored", rx_ready, 0);
        send_frame(9'h081, 1'b0, 1'b1, -1);
        check("R12 next frame", head_of(), 32'h081);
        pop_word();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule